// File: doc/BRIEF.md
# Pipelined Key/Index Sorting Network

This block sorts a fixed-size tuple of records by key. Each record is an unsigned key with a small index payload beside it. A tuple arrives as N key/index pairs on a flat input bus, together with a single valid bit. The same pairs leave in ascending key order after a fixed number of clocks, and the valid bit travels with them.

Every stage of the network is a row of compare-and-swap cells followed by one register stage. A new tuple can therefore enter on every clock, with no stall and no handshake. Only the keys are compared. The index rides with its key through every exchange, so a caller can sort records by key and then use the index to fetch the rest of each record.

Two topologies are built from the same code:
- The default, eight lanes, is an odd-even transposition network of N stages. Its stages alternate between exchanging pairs that start on even lanes and pairs that start on odd lanes.
- With four lanes the block uses a compact network of 5 comparators in 3 stages.

Lane 0 is the least significant slice of each bus. On the output, lane 0 carries the smallest key.

Top module: `sortnet_top`

## Requirements
- R1: With eight lanes, whenever `out_valid` is high, the keys on `out_keys` are the keys of the matching input tuple in non-decreasing order from lane 0 upward.
- R2: Every output lane carries an index that entered on the same record as its key, so the set of (key, index) pairs leaving equals the set that entered.
- R3: A comparator swaps only when its lower-lane key is strictly greater than its upper-lane key. In the eight-lane network, records with equal keys therefore leave in their original lane order.
- R4: `out_valid` equals `in_valid` delayed by the latency: 8 clocks with eight lanes (one per stage) and 3 clocks with four lanes. The output data belongs to the tuple that was valid at that earlier clock.
- R5: Tuples presented on consecutive clocks are all accepted, and each one leaves correctly sorted on consecutive clocks.
- R6: With four lanes, the 3-stage, 5-comparator network sorts every ordering of four distinct keys, and it sorts tuples that contain repeated keys.
- R7: While `rst_n` is low, and until the internally synchronised release has passed, `out_valid` is low.
- R8: A clock with `in_valid` low yields `out_valid` low at the matching output clock. It does not disturb the valid tuples on either side of it.
- R9: Keys compare as unsigned numbers, so an all-ones key sorts above every other key and zero sorts below every other key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks the input tuple as present this clock |
| in_keys | input | N*KEY_W | Unsorted keys, lane l at bits [l*KEY_W +: KEY_W] |
| in_idx | input | N*IDX_W | Index payloads, lane l at bits [l*IDX_W +: IDX_W] |
| out_valid | output | 1 | Marks the output tuple as meaningful |
| out_keys | output | N*KEY_W | Sorted keys, smallest in lane 0 |
| out_idx | output | N*IDX_W | Index of each output key |

## Verification
The bench builds two instances side by side from the same stimulus. One uses the defaults: eight lanes, 32-bit keys and 8-bit indices, which makes an 8-stage transposition network. The other uses four lanes and takes the low four lanes of each tuple, which makes the 3-stage compact network. The eight-lane build gives the bench stable ordering of duplicates and full-width unsigned extremes. The four-lane build makes it cheap to sweep all 24 orderings of four keys. Both instances are compared against a stable software sort on every clock, so streaming and bubbles are checked under both latencies at once.

// File: rtl/sortnet_pkg.sv
`timescale 1ns/1ps
package sortnet_pkg;

  // Number of pipeline stages for a given lane count.
  function automatic int stage_count(input int lanes);
    if (lanes == 4) return 3;
    return lanes;
  endfunction

  // Lane that `lane` is paired with in stage `st`, or -1 when it idles.
  function automatic int partner(input int lanes, input int st, input int lane);
    if (lanes == 4) begin
      case (st)
        0: return lane ^ 1;
        1: return lane ^ 2;
        default: begin
          if (lane == 1) return 2;
          if (lane == 2) return 1;
          return -1;
        end
      endcase
    end
    if ((st % 2) == 0) begin
      if ((lane ^ 1) < lanes) return lane ^ 1;
      return -1;
    end
    if (lane == 0 || lane == lanes - 1) return -1;
    if ((lane % 2) == 1) return lane + 1;
    return lane - 1;
  endfunction

endpackage

// File: rtl/sortnet_cmpx.sv
`timescale 1ns/1ps
module sortnet_cmpx #(
  parameter int KW = 32,
  parameter int IW = 8
) (
  input  logic [KW-1:0] a_key,
  input  logic [IW-1:0] a_idx,
  input  logic [KW-1:0] b_key,
  input  logic [IW-1:0] b_idx,
  output logic [KW-1:0] lo_key,
  output logic [IW-1:0] lo_idx,
  output logic [KW-1:0] hi_key,
  output logic [IW-1:0] hi_idx
);
  logic swap;

  // Strictly greater: equal keys stay where they are.
  always_comb begin
    swap = a_key > b_key;
    if (swap) begin
      lo_key = b_key;  lo_idx = b_idx;
      hi_key = a_key;  hi_idx = a_idx;
    end else begin
      lo_key = a_key;  lo_idx = a_idx;
      hi_key = b_key;  hi_idx = b_idx;
    end
  end
endmodule

// File: rtl/sortnet_stage.sv
`timescale 1ns/1ps
module sortnet_stage #(
  parameter int N     = 8,
  parameter int KW    = 32,
  parameter int IW    = 8,
  parameter int STAGE = 0
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [N-1:0][KW-1:0]  key_i,
  input  logic [N-1:0][IW-1:0]  idx_i,
  output logic                  vld_o,
  output logic [N-1:0][KW-1:0]  key_o,
  output logic [N-1:0][IW-1:0]  idx_o
);
  localparam int SW = KW + $clog2(N) + 1;

  logic [N-1:0][KW-1:0] key_nx;
  logic [N-1:0][IW-1:0] idx_nx;
  logic [N-1:0][KW-1:0] key_q;
  logic [N-1:0][IW-1:0] idx_q;
  logic                 vld_q;
  logic                 load_en;

  // Next-state network: one compare-exchange per active pair
  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam int P = sortnet_pkg::partner(N, STAGE, g);
    if (P < 0) begin : g_idle
      assign key_nx[g] = key_i[g];
      assign idx_nx[g] = idx_i[g];
    end else if (P > g) begin : g_cell
      sortnet_cmpx #(.KW(KW), .IW(IW)) u_cmpx (
        .a_key (key_i[g]),  .a_idx (idx_i[g]),
        .b_key (key_i[P]),  .b_idx (idx_i[P]),
        .lo_key(key_nx[g]), .lo_idx(idx_nx[g]),
        .hi_key(key_nx[P]), .hi_idx(idx_nx[P])
      );
      // R3: equal keys keep their indices in place
      p_equal_kept_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        (vld_q && $past(vld_i) && $past(key_i[g] == key_i[P]))
          |-> (idx_q[g] == $past(idx_i[g]) && idx_q[P] == $past(idx_i[P])));
    end
  end

  assign load_en = vld_i;

  // Register process: valid is reset, data only loads under enable
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      key_q <= key_nx;
      idx_q <= idx_nx;
    end
  end

  assign vld_o = vld_q;
  assign key_o = key_q;
  assign idx_o = idx_q;

  // Checker-side sums: a swap must neither create nor lose a record
  logic [SW-1:0] ksum_in, ksum_q;
  logic [IW-1:0] ixor_in, ixor_q;
  always_comb begin
    ksum_in = '0; ksum_q = '0; ixor_in = '0; ixor_q = '0;
    for (int l = 0; l < N; l++) begin
      ksum_in = ksum_in + SW'(key_i[l]);
      ksum_q  = ksum_q  + SW'(key_q[l]);
      ixor_in = ixor_in ^ idx_i[l];
      ixor_q  = ixor_q  ^ idx_q[l];
    end
  end

  p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q == $past(vld_i));

  p_keys_conserved_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (vld_q && $past(vld_i)) |-> (ksum_q == $past(ksum_in) && ixor_q == $past(ixor_in)));

endmodule

// File: rtl/sortnet_top.sv
`timescale 1ns/1ps
module sortnet_top #(
  parameter int N     = 8,
  parameter int KEY_W = 32,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*KEY_W-1:0] in_keys,
  input  logic [N*IDX_W-1:0] in_idx,
  output logic               out_valid,
  output logic [N*KEY_W-1:0] out_keys,
  output logic [N*IDX_W-1:0] out_idx
);
  localparam int LAT = sortnet_pkg::stage_count(N);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                       v_chain [LAT+1];
  logic [N-1:0][KEY_W-1:0]    k_chain [LAT+1];
  logic [N-1:0][IDX_W-1:0]    i_chain [LAT+1];

  assign v_chain[0] = in_valid;
  assign k_chain[0] = in_keys;
  assign i_chain[0] = in_idx;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    sortnet_stage #(.N(N), .KW(KEY_W), .IW(IDX_W), .STAGE(s)) u_stage (
      .clk   (clk),
      .rst_ni(rst_int_n),
      .vld_i (v_chain[s]),
      .key_i (k_chain[s]),
      .idx_i (i_chain[s]),
      .vld_o (v_chain[s+1]),
      .key_o (k_chain[s+1]),
      .idx_o (i_chain[s+1])
    );
  end

  assign out_valid = v_chain[LAT];
  assign out_keys  = k_chain[LAT];
  assign out_idx   = i_chain[LAT];

  // R1: every valid output tuple is in ascending key order
  for (genvar j = 0; j < N - 1; j++) begin : g_ord
    p_out_ordered_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
      out_valid |-> (k_chain[LAT][j] <= k_chain[LAT][j+1]));
  end

  // R7: no valid output while the internal reset is held
  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_int_n |-> !out_valid);

endmodule

// File: tb/tb_sortnet_top.sv
`timescale 1ns/1ps
module tb_sortnet_top;
  localparam int KW = 32;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [7:0][KW-1:0] in_keys;
  logic [7:0][IW-1:0] in_idx;
  logic out_valid, out_valid4;
  logic [8*KW-1:0] out_keys;
  logic [8*IW-1:0] out_idx;
  logic [4*KW-1:0] out_keys4;
  logic [4*IW-1:0] out_idx4;

  always #2.5 clk = ~clk;

  sortnet_top #(.N(8), .KEY_W(KW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_keys(in_keys), .in_idx(in_idx),
    .out_valid(out_valid), .out_keys(out_keys), .out_idx(out_idx));

  sortnet_top #(.N(4), .KEY_W(KW), .IDX_W(IW)) dut_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_keys(in_keys[3:0]), .in_idx(in_idx[3:0]),
    .out_valid(out_valid4), .out_keys(out_keys4), .out_idx(out_idx4));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic               h_v   [256];
  logic [7:0][KW-1:0] h_key [256];
  logic [7:0][IW-1:0] h_idx [256];
  string              h_tag [256];

  task automatic fail(input string msg);
    failures++;
    $display("FAIL %s", msg);
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // Stable insertion sort over the first n lanes
  task automatic ref_sort(input int n, input logic [7:0][KW-1:0] k, input logic [7:0][IW-1:0] ix,
                          output logic [7:0][KW-1:0] ko, output logic [7:0][IW-1:0] io);
    ko = k; io = ix;
    for (int a = 1; a < n; a++) begin
      for (int b = a; b > 0 && ko[b-1] > ko[b]; b--) begin
        logic [KW-1:0] tk; logic [IW-1:0] ti;
        tk = ko[b]; ko[b] = ko[b-1]; ko[b-1] = tk;
        ti = io[b]; io[b] = io[b-1]; io[b-1] = ti;
      end
    end
  endtask

  task automatic check8();
    int c; logic ev; logic [7:0][KW-1:0] ek; logic [7:0][IW-1:0] ei;
    c = cyc - 8;
    ev = (c >= 0) ? h_v[c % 256] : 1'b0;
    checks++;
    if (out_valid !== ev) fail($sformatf("R4/R8 n8 out_valid act=%0b exp=%0b", out_valid, ev));
    if (ev) begin
      ref_sort(8, h_key[c % 256], h_idx[c % 256], ek, ei);
      checks++;
      if (out_keys !== ek) fail($sformatf("R1 n8 %s keys act=%h exp=%h", h_tag[c % 256], out_keys, ek));
      checks++;
      if (out_idx !== ei) fail($sformatf("R2/R3 n8 %s idx act=%h exp=%h", h_tag[c % 256], out_idx, ei));
    end
  endtask

  task automatic check4();
    int c; logic ev; logic [7:0][KW-1:0] ek; logic [7:0][IW-1:0] ei;
    logic [3:0][KW-1:0] ok; logic [3:0][IW-1:0] oi; int cnt_o, cnt_i;
    c = cyc - 3;
    ev = (c >= 0) ? h_v[c % 256] : 1'b0;
    checks++;
    if (out_valid4 !== ev) fail($sformatf("R4/R8 n4 out_valid act=%0b exp=%0b", out_valid4, ev));
    if (ev) begin
      ref_sort(4, h_key[c % 256], h_idx[c % 256], ek, ei);
      ok = out_keys4; oi = out_idx4;
      checks++;
      if (ok !== ek[3:0]) fail($sformatf("R6 n4 %s keys act=%h exp=%h", h_tag[c % 256], ok, ek[3:0]));
      checks++;
      for (int j = 0; j < 4; j++) begin
        cnt_o = 0; cnt_i = 0;
        for (int m = 0; m < 4; m++) begin
          if (ok[m] == ok[j] && oi[m] == oi[j]) cnt_o++;
          if (h_key[c % 256][m] == ok[j] && h_idx[c % 256][m] == oi[j]) cnt_i++;
        end
        if (cnt_o != cnt_i)
          fail($sformatf("R2 n4 %s pair lane%0d act=%0d/%0d exp=%0d", h_tag[c % 256], j, ok[j], oi[j], cnt_i));
      end
    end
  endtask

  // One clock: check outputs due now, then drive and record the next tuple
  task automatic step(input logic v, input logic [7:0][KW-1:0] k, input string tag);
    logic [7:0][IW-1:0] ix;
    @(negedge clk);
    check8();
    check4();
    for (int l = 0; l < 8; l++) ix[l] = IW'(l);
    in_valid = v; in_keys = k; in_idx = ix;
    h_v[cyc % 256] = v; h_key[cyc % 256] = k; h_idx[cyc % 256] = ix; h_tag[cyc % 256] = tag;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, "idle");
  endtask

  function automatic logic [7:0][KW-1:0] rnd_tuple();
    logic [7:0][KW-1:0] t;
    for (int l = 0; l < 8; l++) t[l] = rnd();
    return t;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; in_keys = '1; in_idx = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_valid4 !== 1'b0)
      fail($sformatf("R7 valid in reset act=%0b/%0b exp=0/0", out_valid, out_valid4));
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_valid4 !== 1'b0)
      fail($sformatf("R7 valid after release act=%0b/%0b exp=0/0", out_valid, out_valid4));
  endtask

  task automatic t_single();
    logic [7:0][KW-1:0] t;
    for (int l = 0; l < 8; l++) t[l] = 32'(100 - 10 * l);
    step(1'b1, t, "R1 reversed"); idle(9);
    for (int l = 0; l < 8; l++) t[l] = 32'(5 + l);
    step(1'b1, t, "R1 sorted"); idle(9);
    step(1'b1, rnd_tuple(), "R1 random"); idle(9);
  endtask

  task automatic t_dups();
    logic [7:0][KW-1:0] t;
    t = {32'd7, 32'd3, 32'd7, 32'd1, 32'd3, 32'd7, 32'd1, 32'd3};
    step(1'b1, t, "R3 duplicates"); idle(9);
    for (int l = 0; l < 8; l++) t[l] = 32'd42;
    step(1'b1, t, "R3 all equal"); idle(9);
  endtask

  task automatic t_extremes();
    logic [7:0][KW-1:0] t;
    t = {32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'hFFFF_FFFE};
    step(1'b1, t, "R9 unsigned extremes"); idle(9);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 20; i++) begin
      logic [7:0][KW-1:0] t;
      t = rnd_tuple();
      if (i % 4 == 0) for (int l = 0; l < 8; l++) t[l] = t[l] & 32'h3;
      step(1'b1, t, "R5 stream");
    end
    idle(9);
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 12; i++) step((i % 3) != 1, rnd_tuple(), "R8 bubbles");
    idle(9);
  endtask

  task automatic t_perm4();
    logic [3:0][KW-1:0] base;
    base = {32'd40, 32'd30, 32'd20, 32'd10};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              logic [7:0][KW-1:0] t;
              t = rnd_tuple();
              t[0] = base[a]; t[1] = base[b]; t[2] = base[c]; t[3] = base[d];
              step(1'b1, t, "R6 permutation");
            end
    begin
      logic [7:0][KW-1:0] t;
      t = rnd_tuple();
      t[0] = 32'd9; t[1] = 32'd2; t[2] = 32'd9; t[3] = 32'd2;
      step(1'b1, t, "R6 repeated");
    end
    idle(9);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin h_v[i] = 1'b0; h_key[i] = '0; h_idx[i] = '0; h_tag[i] = ""; end
    t_reset();
    t_single();
    t_dups();
    t_extremes();
    t_stream();
    t_bubbles();
    t_perm4();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule